// File: doc/BRIEF.md
# Authenticated Scratchpad Commit Controller

This block guards a small non-volatile data store (four pages of 32 bytes, held here in registers) that can only be changed through an 8-byte staging buffer. A serial command layer in front of it delivers whole bytes and framing pulses. A transaction opens with `start` and a command code. It may carry data bytes on `rx_valid`/`rx_byte`, and it closes with `stop`. Three commands exist: load the staging buffer, read it back together with its address and status bytes, and commit it to the data store.

A load sends a two-byte target address and then up to eight data bytes. The address is always snapped down to an 8-byte boundary. A status byte records how far the load got and whether it was cut short. A commit requires the master to echo the address and status bytes exactly. It also requires a clean, complete load and a confirmation pulse on `auth_ok`, which an external message-authentication engine drives. Protection rules are then applied. Page write protection can block the commit. One page can run in one-time-programmable emulation, where a bit may only fall from 1 to 0. Every commit attempt that gets an outcome ends in exactly one of two pulses, `copy_done` or `copy_refused`.

The serial layer assembles the bits of each byte least significant bit first. This block only sees complete or flagged-incomplete bytes. A read port lets the surrounding logic observe the data store.

Top module: `auth_scratch_ctrl`

## Requirements
- R1: After reset the staging buffer is all 0xFF, both address bytes are 0x00, the status byte is 0x20 (incomplete flag set, offset 0), every data store byte is 0xFF, and the protection mode and emulation enable are taken from `prot_init` and `otp_init`.
- R2: In a load (`cmd` = 1), the first byte becomes the low address byte with bits 2:0 forced to 0. The second becomes the high address byte. Data bytes then fill buffer slots 0 to 7 in order, and full bytes beyond the eighth are ignored.
- R3: A load that delivers eight full data bytes leaves the status byte at 0x07 (bit 5 incomplete flag clear, bits 2:0 ending offset 7).
- R4: A load that ends with fewer than eight data bytes, or that receives a byte with `rx_full` low, leaves bit 5 of the status byte set and bits 2:0 equal to the slot of the last stored byte (0 if none). The flagged byte is not stored, and all later bytes of that load are ignored.
- R5: A read (`cmd` = 2) returns, one byte per `tx_next`, the low address byte, the high address byte, the status byte, buffer slots 0 to 7, and 0xFF from then on.
- R6: A commit (`cmd` = 3) whose three echoed bytes differ from the low address, high address and status bytes, or that follows an incomplete load, is refused and leaves the data store unchanged.
- R7: After a correct echo the commit waits for `auth_ok`. A pulse writes all eight buffer bytes to the addressed 8-byte block. A `stop` before the pulse refuses the commit.
- R8: Protection mode encoding: 0 none, 1 page 0, 2 page 3, 3 all pages. A commit to a protected page is refused and leaves the data store unchanged.
- R9: With emulation enabled, a commit to page 1 stores the bitwise AND of the old and new bytes. Other pages, and page 1 with emulation disabled, are overwritten.
- R10: Each decided commit raises exactly one of `copy_done` or `copy_refused` for one cycle, starting the cycle after the deciding clock edge. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a transaction with the code on `cmd` (only while idle) |
| cmd | input | 2 | Command: 1 load, 2 read, 3 commit |
| stop | input | 1 | Closes the current transaction |
| rx_valid | input | 1 | A byte from the serial layer is present |
| rx_byte | input | 8 | Received byte |
| rx_full | input | 1 | High if all eight bits of the byte arrived |
| tx_next | input | 1 | Advances the read stream by one byte |
| tx_byte | output | 8 | Current byte of the read stream (0xFF outside a read) |
| auth_ok | input | 1 | Authentication-confirmed pulse from the external engine |
| prot_init | input | 2 | Protection mode loaded at reset |
| otp_init | input | 1 | Page 1 emulation enable loaded at reset |
| rd_addr | input | 7 | Data store observation address |
| rd_data | output | 8 | Data store byte at `rd_addr` |
| copy_done | output | 1 | Commit performed |
| copy_refused | output | 1 | Commit refused |

## Verification
Loads are driven complete, short, with a flagged byte in the middle, and overlong. This tells the offset counting apart from the incomplete flag and from the slot-overrun guard. Commits are tried with a wrong address echo, after an incomplete load, without the confirmation pulse, and with it. A table then crosses each protection mode with target pages inside and outside its reach. It also runs back-to-back commits to the emulated page and to an ordinary page, so that AND-merging is separated from plain overwrite.

// File: rtl/asc_pkg.sv
package asc_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2,
        CMD_COPY  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        PROT_NONE  = 2'd0,
        PROT_PAGE0 = 2'd1,
        PROT_PAGE3 = 2'd2,
        PROT_ALL   = 2'd3
    } prot_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_TA1,
        ST_W_TA2,
        ST_W_DATA,
        ST_R_STREAM,
        ST_C_TA1,
        ST_C_TA2,
        ST_C_ES,
        ST_C_AUTH,
        ST_SINK
    } st_e;

    localparam int PARTIAL_BIT = 5;

endpackage

// File: rtl/asc_policy.sv
module asc_policy #(
    parameter int SP_BYTES  = 8,
    parameter int PAGES     = 4,
    parameter int OTP_PAGE  = 1,
    localparam int PAGE_BITS = $clog2(PAGES)
) (
    input  logic [PAGE_BITS-1:0]      page,
    input  logic [1:0]                prot_mode,
    input  logic                      otp_en,
    input  logic [SP_BYTES-1:0][7:0]  old_blk,
    input  logic [SP_BYTES-1:0][7:0]  new_blk,
    output logic                      allow,
    output logic [SP_BYTES-1:0][7:0]  merged
);
    import asc_pkg::*;

    logic locked;
    logic and_only;

    always_comb begin
        case (prot_e'(prot_mode))
            PROT_PAGE0: locked = (page == '0);
            PROT_PAGE3: locked = (page == PAGE_BITS'(PAGES - 1));
            PROT_ALL:   locked = 1'b1;
            default:    locked = 1'b0;
        endcase
    end

    assign allow    = !locked;
    assign and_only = otp_en && (page == PAGE_BITS'(OTP_PAGE));

    for (genvar g = 0; g < SP_BYTES; g++) begin : g_lane
        assign merged[g] = and_only ? (old_blk[g] & new_blk[g]) : new_blk[g];
    end

endmodule

// File: rtl/asc_mem.sv
module asc_mem #(
    parameter int BYTES    = 128,
    parameter int SP_BYTES = 8,
    parameter logic [7:0] INIT = 8'hFF,
    localparam int AW    = $clog2(BYTES),
    localparam int OFS_W = $clog2(SP_BYTES),
    localparam int BLK_W = AW - OFS_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [BLK_W-1:0]          blk,
    input  logic [SP_BYTES-1:0][7:0]  wdata,
    input  logic [AW-1:0]             rd_addr,
    output logic [7:0]                rd_data,
    output logic [SP_BYTES-1:0][7:0]  blk_rd
);
    logic [7:0] cells [BYTES];

    for (genvar i = 0; i < BYTES; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[i] <= INIT;
            end else if (we && (blk == BLK_W'(i / SP_BYTES))) begin
                cells[i] <= wdata[i % SP_BYTES];
            end
        end
    end

    for (genvar j = 0; j < SP_BYTES; j++) begin : g_blk
        assign blk_rd[j] = cells[{blk, OFS_W'(j)}];
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/asc_seq.sv
module asc_seq #(
    parameter int SP_BYTES = 8,
    parameter int AW       = 7,
    parameter int PAGES    = 4,
    localparam int OFS_W     = $clog2(SP_BYTES),
    localparam int BLK_W     = AW - OFS_W,
    localparam int PAGE_BITS = $clog2(PAGES),
    localparam int IDX_W     = $clog2(SP_BYTES + 4)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [1:0]                cmd,
    input  logic                      stop,
    input  logic                      rx_valid,
    input  logic [7:0]                rx_byte,
    input  logic                      rx_full,
    input  logic                      tx_next,
    input  logic                      auth_ok,
    input  logic                      allow,
    input  logic [1:0]                prot_init,
    input  logic                      otp_init,
    output logic [7:0]                tx_byte,
    output logic                      mem_we,
    output logic [SP_BYTES-1:0][7:0]  sp_data,
    output logic [BLK_W-1:0]          blk_idx,
    output logic [PAGE_BITS-1:0]      page,
    output logic [1:0]                prot_mode,
    output logic                      otp_en,
    output logic [7:0]                ta1_o,
    output logic [7:0]                es_o,
    output logic                      copy_done,
    output logic                      copy_refused
);
    import asc_pkg::*;

    localparam logic [IDX_W-1:0] IDX_SP0  = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(SP_BYTES + 3);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SP_BYTES - 1);

    typedef struct packed {
        st_e                      st;
        logic [7:0]               ta1;
        logic [7:0]               ta2;
        logic                     partial;
        logic [OFS_W-1:0]         ofs;
        logic [SP_BYTES-1:0][7:0] sp;
        logic [IDX_W-1:0]         idx;
        logic                     echo_ok;
        logic                     done;
        logic                     refused;
        logic [1:0]               prot;
        logic                     otp;
    } seq_s;

    seq_s q, d, rst_v;
    logic [7:0] es_now;

    always_comb begin
        es_now              = '0;
        es_now[PARTIAL_BIT] = q.partial;
        es_now[OFS_W-1:0]   = q.ofs;
    end

    always_comb begin
        rst_v         = '0;
        rst_v.partial = 1'b1;
        rst_v.sp      = '1;
        rst_v.prot    = prot_init;
        rst_v.otp     = otp_init;
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.refused = 1'b0;
        mem_we    = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    case (cmd_e'(cmd))
                        CMD_WRITE: begin
                            d.st      = ST_W_TA1;
                            d.partial = 1'b1;
                        end
                        CMD_READ: begin
                            d.st  = ST_R_STREAM;
                            d.idx = '0;
                        end
                        CMD_COPY: begin
                            d.st      = ST_C_TA1;
                            d.echo_ok = 1'b1;
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end
            end
            ST_W_TA1: begin
                if (rx_valid) begin
                    if (rx_full) begin
                        d.ta1 = {rx_byte[7:OFS_W], {OFS_W{1'b0}}};
                        d.st  = ST_W_TA2;
                    end else begin
                        d.st = ST_SINK;
                    end
                end
            end
            ST_W_TA2: begin
                if (rx_valid) begin
                    if (rx_full) begin
                        d.ta2 = rx_byte;
                        d.ofs = '0;
                        d.idx = '0;
                        d.st  = ST_W_DATA;
                    end else begin
                        d.st = ST_SINK;
                    end
                end
            end
            ST_W_DATA: begin
                if (rx_valid) begin
                    if (rx_full) begin
                        d.sp[q.idx[OFS_W-1:0]] = rx_byte;
                        d.ofs = q.idx[OFS_W-1:0];
                        if (q.idx == IDX_LAST) begin
                            d.partial = 1'b0;
                            d.st      = ST_SINK;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.st = ST_SINK;
                    end
                end
            end
            ST_R_STREAM: begin
                if (tx_next && (q.idx != IDX_END)) d.idx = q.idx + 1'b1;
            end
            ST_C_TA1: begin
                if (rx_valid) begin
                    d.echo_ok = q.echo_ok && rx_full && (rx_byte == q.ta1);
                    d.st      = ST_C_TA2;
                end
            end
            ST_C_TA2: begin
                if (rx_valid) begin
                    d.echo_ok = q.echo_ok && rx_full && (rx_byte == q.ta2);
                    d.st      = ST_C_ES;
                end
            end
            ST_C_ES: begin
                if (rx_valid) begin
                    if (q.echo_ok && rx_full && (rx_byte == es_now) && !q.partial) begin
                        d.st = ST_C_AUTH;
                    end else begin
                        d.refused = 1'b1;
                        d.st      = ST_SINK;
                    end
                end
            end
            ST_C_AUTH: begin
                if (auth_ok) begin
                    if (allow) begin
                        mem_we = 1'b1;
                        d.done = 1'b1;
                    end else begin
                        d.refused = 1'b1;
                    end
                    d.st = ST_SINK;
                end
            end
            default: d.st = q.st;
        endcase

        if (stop) begin
            if ((q.st inside {ST_C_TA1, ST_C_TA2, ST_C_ES, ST_C_AUTH}) && !d.done && !d.refused)
                d.refused = 1'b1;
            d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= rst_v;
        else        q <= d;
    end

    always_comb begin
        tx_byte = 8'hFF;
        if (q.st == ST_R_STREAM) begin
            if (q.idx == IDX_W'(0))      tx_byte = q.ta1;
            else if (q.idx == IDX_W'(1)) tx_byte = q.ta2;
            else if (q.idx == IDX_W'(2)) tx_byte = es_now;
            else if (q.idx < IDX_END)    tx_byte = q.sp[OFS_W'(q.idx - IDX_SP0)];
        end
    end

    assign sp_data      = q.sp;
    assign blk_idx      = q.ta1[AW-1:OFS_W];
    assign page         = q.ta1[AW-1:AW-PAGE_BITS];
    assign prot_mode    = q.prot;
    assign otp_en       = q.otp;
    assign ta1_o        = q.ta1;
    assign es_o         = es_now;
    assign copy_done    = q.done;
    assign copy_refused = q.refused;

endmodule

// File: rtl/auth_scratch_ctrl.sv
module auth_scratch_ctrl #(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 32,
    parameter int SP_BYTES   = 8,
    parameter int OTP_PAGE   = 1,
    localparam int MEM_BYTES = PAGES * PAGE_BYTES,
    localparam int AW        = $clog2(MEM_BYTES),
    localparam int OFS_W     = $clog2(SP_BYTES),
    localparam int BLK_W     = AW - OFS_W,
    localparam int PAGE_BITS = $clog2(PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cmd,
    input  logic          stop,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rx_full,
    input  logic          tx_next,
    output logic [7:0]    tx_byte,
    input  logic          auth_ok,
    input  logic [1:0]    prot_init,
    input  logic          otp_init,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          copy_done,
    output logic          copy_refused
);
    logic                     mem_we;
    logic                     allow;
    logic [SP_BYTES-1:0][7:0] sp_data;
    logic [SP_BYTES-1:0][7:0] old_blk;
    logic [SP_BYTES-1:0][7:0] merged;
    logic [BLK_W-1:0]         blk_idx;
    logic [PAGE_BITS-1:0]     page;
    logic [1:0]               prot_mode;
    logic                     otp_en;
    logic [7:0]               ta1_w;
    logic [7:0]               es_w;

    asc_seq #(.SP_BYTES(SP_BYTES), .AW(AW), .PAGES(PAGES)) u_seq (
        .clk, .rst_n, .start, .cmd, .stop, .rx_valid, .rx_byte, .rx_full,
        .tx_next, .auth_ok, .allow, .prot_init, .otp_init, .tx_byte,
        .mem_we, .sp_data, .blk_idx, .page, .prot_mode, .otp_en,
        .ta1_o(ta1_w), .es_o(es_w), .copy_done, .copy_refused
    );

    asc_policy #(.SP_BYTES(SP_BYTES), .PAGES(PAGES), .OTP_PAGE(OTP_PAGE)) u_policy (
        .page, .prot_mode, .otp_en, .old_blk, .new_blk(sp_data), .allow, .merged
    );

    asc_mem #(.BYTES(MEM_BYTES), .SP_BYTES(SP_BYTES)) u_mem (
        .clk, .rst_n, .we(mem_we), .blk(blk_idx), .wdata(merged),
        .rd_addr, .rd_data, .blk_rd(old_blk)
    );

endmodule

// File: rtl/asc_checker.sv
module asc_checker #(
    parameter int OFS_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_we,
    input logic             allow,
    input logic             copy_done,
    input logic             copy_refused,
    input logic [OFS_W-1:0] ta1_low,
    input logic             es_partial,
    input logic [OFS_W-1:0] es_ofs
);
    p_ta1_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ta1_low == '0);

    p_clean_means_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !es_partial |-> (es_ofs == '1));

    p_no_commit_partial_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !es_partial);

    p_commit_reports_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> copy_done);

    p_done_after_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done |-> $past(mem_we));

    p_no_commit_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> allow);

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(copy_done && copy_refused));

endmodule

bind auth_scratch_ctrl asc_checker #(.OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .allow(allow),
    .copy_done(copy_done), .copy_refused(copy_refused),
    .ta1_low(ta1_w[OFS_W-1:0]), .es_partial(es_w[5]), .es_ofs(es_w[OFS_W-1:0])
);

// File: tb/auth_scratch_ctrl_test.sv
module auth_scratch_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cmd = 2'd0;
    logic       stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_full = 1'b1;
    logic       tx_next = 1'b0;
    logic [7:0] tx_byte;
    logic       auth_ok = 1'b0;
    logic [1:0] prot_init = 2'd0;
    logic       otp_init = 1'b0;
    logic [6:0] rd_addr = 7'd0;
    logic [7:0] rd_data;
    logic       copy_done;
    logic       copy_refused;

    auth_scratch_ctrl uut (
        .clk, .rst_n, .start, .cmd, .stop, .rx_valid, .rx_byte, .rx_full,
        .tx_next, .tx_byte, .auth_ok, .prot_init, .otp_init, .rd_addr,
        .rd_data, .copy_done, .copy_refused
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;
    int n_ref = 0;
    logic [7:0] rb [12];

    always @(negedge clk) begin
        if (copy_done)    n_done++;
        if (copy_refused) n_ref++;
    end

    typedef struct packed {
        logic [7:0] ta1;
        logic [7:0] b1;
        logic [7:0] b2;
        logic       two;
        logic [1:0] prot;
        logic       otp;
        logic       auth;
        logic       ok;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'h00, 8'h10, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1},
        '{8'h08, 8'h20, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0},
        '{8'h68, 8'h31, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1},
        '{8'h70, 8'h42, 8'h00, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0},
        '{8'h28, 8'h53, 8'h00, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0},
        '{8'h30, 8'hF3, 8'h5C, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1},
        '{8'h40, 8'hF3, 8'h5C, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1},
        '{8'h20, 8'h64, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
        '{8'h38, 8'hC7, 8'h1A, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1}
    };

    function automatic logic [7:0] pat(input logic [7:0] b, input int i);
        return b + 8'(i * 17);
    endfunction

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] p, input logic o);
        prot_init = p;
        otp_init  = o;
        rst_n     = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic do_start(input logic [1:0] c);
        start = 1'b1;
        cmd   = c;
        tick();
        start = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b, input logic full);
        rx_valid = 1'b1;
        rx_byte  = b;
        rx_full  = full;
        tick();
        rx_valid = 1'b0;
        rx_full  = 1'b1;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        tick();
        stop = 1'b0;
        tick();
    endtask

    task automatic write_block(input logic [7:0] a, input logic [7:0] base, input int n);
        do_start(2'd1);
        do_byte(a, 1'b1);
        do_byte(8'h00, 1'b1);
        for (int i = 0; i < n; i++) do_byte(pat(base, i), 1'b1);
        do_stop();
    endtask

    task automatic read_all();
        do_start(2'd2);
        for (int i = 0; i < 12; i++) begin
            rb[i]   = tx_byte;
            tx_next = 1'b1;
            tick();
        end
        tx_next = 1'b0;
        do_stop();
    endtask

    task automatic do_copy(input logic [7:0] a, input logic [7:0] es, input logic give_auth);
        do_start(2'd3);
        do_byte(a, 1'b1);
        do_byte(8'h00, 1'b1);
        do_byte(es, 1'b1);
        if (give_auth) begin
            auth_ok = 1'b1;
            tick();
            auth_ok = 1'b0;
        end
        do_stop();
    endtask

    task automatic mem_at(input int addr, output logic [7:0] v);
        rd_addr = 7'(addr);
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [7:0] m;
        int d0;
        int r0;
        vec_t e;

        do_reset(2'd0, 1'b0);

        // R1 reset state
        read_all();
        check("R1 ta1", rb[0], 8'h00);
        check("R1 ta2", rb[1], 8'h00);
        check("R1 status", rb[2], 8'h20);
        for (int i = 0; i < 8; i++) check("R1 scratch", rb[3 + i], 8'hFF);
        mem_at(0, m);   check("R1 mem low", m, 8'hFF);
        mem_at(127, m); check("R1 mem high", m, 8'hFF);

        // R2 R3 R5 full load, alignment and read order
        write_block(8'h4D, 8'hA0, 8);
        read_all();
        check("R2 aligned ta1", rb[0], 8'h48);
        check("R5 ta2", rb[1], 8'h00);
        check("R3 status full", rb[2], 8'h07);
        for (int i = 0; i < 8; i++) check("R2 slot data", rb[3 + i], pat(8'hA0, i));
        check("R5 tail", rb[11], 8'hFF);

        // R4 short load
        write_block(8'h10, 8'h30, 3);
        read_all();
        check("R4 status short", rb[2], 8'h22);
        check("R4 slot2 new", rb[5], pat(8'h30, 2));
        check("R4 slot3 old", rb[6], pat(8'hA0, 3));

        // R4 flagged byte in the middle
        do_start(2'd1);
        do_byte(8'h10, 1'b1);
        do_byte(8'h00, 1'b1);
        do_byte(8'h55, 1'b1);
        do_byte(8'h66, 1'b1);
        do_byte(8'h77, 1'b0);
        do_byte(8'h88, 1'b1);
        do_stop();
        read_all();
        check("R4 status flagged", rb[2], 8'h21);
        check("R4 slot1 stored", rb[4], 8'h66);
        check("R4 flagged not stored", rb[5], pat(8'h30, 2));
        check("R4 later ignored", rb[6], pat(8'hA0, 3));

        // R6 commit after incomplete load
        d0 = n_done; r0 = n_ref;
        do_copy(8'h10, 8'h21, 1'b1);
        check("R6 partial refused", 8'(n_ref - r0), 8'd1);
        check("R10 partial no done", 8'(n_done - d0), 8'd0);
        mem_at(16, m); check("R6 mem untouched", m, 8'hFF);

        // R2 overlong load
        write_block(8'h18, 8'h77, 10);
        read_all();
        check("R2 overrun slot0", rb[3], pat(8'h77, 0));
        check("R2 overrun slot7", rb[10], pat(8'h77, 7));
        check("R3 status overrun", rb[2], 8'h07);

        // R6 wrong address echo
        d0 = n_done; r0 = n_ref;
        do_copy(8'h10, 8'h07, 1'b1);
        check("R6 echo refused", 8'(n_ref - r0), 8'd1);
        mem_at(24, m); check("R6 echo mem untouched", m, 8'hFF);

        // R7 no confirmation
        r0 = n_ref;
        do_copy(8'h18, 8'h07, 1'b0);
        check("R7 no auth refused", 8'(n_ref - r0), 8'd1);
        mem_at(24, m); check("R7 no auth mem untouched", m, 8'hFF);

        // R7 R10 accepted commit
        d0 = n_done; r0 = n_ref;
        do_copy(8'h18, 8'h07, 1'b1);
        check("R10 one done", 8'(n_done - d0), 8'd1);
        check("R10 no refuse", 8'(n_ref - r0), 8'd0);
        for (int i = 0; i < 8; i++) begin
            mem_at(24 + i, m);
            check("R7 committed", m, pat(8'h77, i));
        end

        // R8 R9 protection and emulation table
        for (int v = 0; v < 9; v++) begin
            logic [7:0] ex;
            int ncopy;
            e = VECS[v];
            do_reset(e.prot, e.otp);
            d0 = n_done; r0 = n_ref;
            write_block(e.ta1, e.b1, 8);
            do_copy(e.ta1, 8'h07, e.auth);
            ncopy = 1;
            if (e.two) begin
                write_block(e.ta1, e.b2, 8);
                do_copy(e.ta1, 8'h07, e.auth);
                ncopy = 2;
            end
            check("R8 done count", 8'(n_done - d0), e.ok ? 8'(ncopy) : 8'd0);
            check("R8 refuse count", 8'(n_ref - r0), e.ok ? 8'd0 : 8'(ncopy));
            for (int i = 0; i < 8; i++) begin
                if (!e.ok)
                    ex = 8'hFF;
                else if (!e.two)
                    ex = pat(e.b1, i);
                else if (e.otp && e.ta1[6:5] == 2'd1)
                    ex = pat(e.b1, i) & pat(e.b2, i);
                else
                    ex = pat(e.b2, i);
                mem_at(int'(e.ta1[6:0]) + i, m);
                check("R9 R8 block byte", m, ex);
            end
        end

        report();
        $finish;
    end

endmodule